// File: doc/BRIEF.md
# Serial-Read Bit FIFO with Status Word

This block stores a demodulated receive bitstream one bit at a time in a 32-entry FIFO and hands it to a host through an SPI slave. A host read is a single chip-select frame. The host shifts in an 8-bit command byte, MSB first. If the command matches the read opcode, the block shifts out a 32-bit window of the FIFO, oldest bit first. A status byte follows, MSB first. It carries a sticky overflow flag and the number of valid bits in the window. Once a read frame completes, the reported bits are removed from the FIFO.

Three events can empty the FIFO. A cycle-start pulse does it when that option is enabled. A telegram-start (frame-start) pulse does it when that option is enabled and the FIFO is unlocked. A frame-start that follows an overflow always empties the FIFO and also clears the overflow flag.

An end-of-message pulse drives the interrupt output. In the normal case the interrupt is a one-cycle pulse. When the lock option is enabled and the receiver is in slave run mode, the interrupt is held active and the FIFO is frozen until the host completes a read.

There are two state machines:
- **SPI frame sequencer:** `SP_IDLE` (chip select high) → `SP_CMD` (command bits). From `SP_CMD` it goes to `SP_DATA` (window and status shifting) on an opcode match, or to `SP_SKIP` (foreign command, output disabled) otherwise. `SP_DATA` goes to `SP_DONE` (all 48 bits clocked). Chip select going high returns every state to `SP_IDLE`. Leaving `SP_DONE` this way commits the read.
- **Interrupt sequencer:** `IQ_IDLE` goes to `IQ_PULSE` (one cycle) on end-of-message, or to `IQ_HOLD` when locking is in effect. `IQ_PULSE` → `IQ_IDLE`. `IQ_HOLD` → `IQ_IDLE` on a committed read.

Top module: `bitfifo_spi_rd`

## Requirements
- R1: After reset the interrupt is inactive, the serial output enable is low, and a first read reports a count of 0 with the overflow flag clear.
- R2: A read frame is 8 command bits sampled on SCK rising edges (mode 0), then 32 window bits and 8 status bits presented on falling edges. The window starts with the oldest stored bit, so window bit k is the k-th oldest bit for every k below the reported count.
- R3: The status byte, sent MSB first, holds the overflow flag in bit 7, an undefined bit 6, and in bits 5..0 the number of valid window bits, which is the stored count capped at 32 (32 is sent as 6'b100000).
- R4: A read frame whose 48 bits all complete removes the reported number of oldest bits. A frame closed by chip select after fewer bits removes nothing.
- R5: Writing a bit while 32 bits are stored and none are being removed sets the overflow flag. The flag stays set across reads until cleared per R6.
- R6: A frame-start pulse while the overflow flag is set clears the flag and empties the FIFO, regardless of the frame-start option and the lock.
- R7: With the cycle-start option set, a cycle-start pulse empties the FIFO. With it clear, the pulse has no effect.
- R8: With the frame-start option set and the FIFO unlocked, a frame-start pulse empties the FIFO. With the option clear, or while locked, it has no effect unless R6 applies.
- R9: An end-of-message pulse, with locking not in effect, makes the interrupt active for exactly the one cycle after the pulse is sampled.
- R10: With the lock option set and slave run mode on, an end-of-message pulse holds the interrupt active and discards incoming bits until a read frame completes. The interrupt then returns to inactive.
- R11: The interrupt polarity input selects an active-high (1) or active-low (0) interrupt output.
- R12: The serial output enable is low whenever chip select is high, and it stays low for the whole of a frame whose command is not the read opcode (default 8'h3C). Such a frame leaves the FIFO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A received bit is present this cycle |
| bit_data | input | 1 | Received bit value |
| frm_start | input | 1 | Telegram-start detected pulse |
| msg_end | input | 1 | End-of-message pulse |
| cycle_start | input | 1 | Cycle-start pulse (entry into a run mode) |
| cfg_init_cycle | input | 1 | Empty FIFO on cycle start |
| cfg_init_frame | input | 1 | Empty FIFO on telegram start when unlocked |
| cfg_lock_en | input | 1 | Enable FIFO lock on end-of-message |
| slave_run | input | 1 | Receiver is in slave run mode |
| cfg_irq_high | input | 1 | 1: active-high interrupt, 0: active-low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, oversampled by clk |
| spi_mosi | input | 1 | SPI serial data in |
| sdo_data | output | 1 | SPI serial data out value |
| sdo_en | output | 1 | Output enable for the serial data pin (low means high impedance) |
| irq_o | output | 1 | Interrupt output at the selected polarity |

## Verification
Several properties are checked on every cycle:
- the stored count never exceeds the depth;
- the overflow flag persists until its clearing event;
- each initialisation leaves the FIFO empty;
- the window load happens exactly when the command byte completes;
- a commit lasts one cycle;
- a held interrupt persists until a read, and a pulse lasts one cycle.

Other behaviours only the bench's scenarios can show, because they compare the serial window and the status byte against the stored history:
- oldest-first ordering;
- the exact count at 32 and past it;
- draining after complete frames and retention after aborted ones;
- bits dropped while locked;
- the interaction of the three initialisation triggers.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_CMD,
        SP_DATA,
        SP_DONE,
        SP_SKIP
    } spi_st_e;

    typedef enum logic [1:0] {
        IQ_IDLE,
        IQ_PULSE,
        IQ_HOLD
    } irq_st_e;

endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             init_req,
    input  logic             ovf_clr,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_n,
    output logic [DEPTH-1:0] window,
    output logic [CNT_W-1:0] level,
    output logic             ovf
);

    logic [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] level_q;
    logic             ovf_q;

    logic [CNT_W-1:0] sub;
    logic [CNT_W-1:0] left;
    logic             ovw;

    always_comb begin
        sub  = '0;
        if (commit) begin
            sub = (commit_n > level_q) ? level_q : commit_n;
        end
        left = level_q - sub;
        ovw  = wr_en && (left == CNT_W'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q   <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
            level_q <= '0;
            ovf_q   <= 1'b0;
        end else if (init_req) begin
            wp_q    <= '0;
            rp_q    <= '0;
            level_q <= '0;
            if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end else begin
            if (wr_en) begin
                mem_q[wp_q] <= wr_bit;
                wp_q        <= wp_q + 1'b1;
            end
            rp_q    <= rp_q + PTR_W'(sub) + PTR_W'(ovw);
            level_q <= ovw ? left : (left + CNT_W'(wr_en));
            if (ovw) begin
                ovf_q <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_win
        assign window[i] = mem_q[rp_q + PTR_W'(i)];
    end

    assign level = level_q;
    assign ovf   = ovf_q;

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CNT_W'(DEPTH))
        else $error("R3: stored count above depth");

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q)
        else $error("R5: overflow flag dropped without its clearing event");

    a_r6_init_empties: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (level_q == '0))
        else $error("R6/R7/R8: initialisation left bits stored");

endmodule

// File: rtl/bfifo_spi.sv
module bfifo_spi
    import bfifo_pkg::*;
#(
    parameter int          DEPTH     = 32,
    parameter int          CMD_W     = 8,
    parameter logic [7:0]  RD_OPCODE = 8'h3C,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int STAT_W  = CNT_W + 2,
    localparam int SHIFT_W = DEPTH + STAT_W,
    localparam int FRM_LEN = CMD_W + SHIFT_W,
    localparam int FRM_CW  = $clog2(FRM_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_csn,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic [DEPTH-1:0] window,
    input  logic [CNT_W-1:0] level,
    input  logic             ovf,
    output logic             sdo_data,
    output logic             sdo_en,
    output logic             commit,
    output logic [CNT_W-1:0] commit_n
);

    localparam logic [FRM_CW-1:0] CMD_LAST = FRM_CW'(CMD_W - 1);
    localparam logic [FRM_CW-1:0] FRM_LAST = FRM_CW'(FRM_LEN - 1);
    localparam logic [FRM_CW-1:0] FRM_END  = FRM_CW'(FRM_LEN);

    spi_st_e st, st_n;

    logic              csn_s, sck_s, sck_d, mosi_s;
    logic              rise, fall;
    logic [FRM_CW-1:0] bit_cnt;
    logic [CMD_W-1:0]  cmd_sh;
    logic [CMD_W-1:0]  cmd_full;
    logic [SHIFT_W-1:0] sh_q;
    logic              out_q;
    logic [CNT_W-1:0]  rep_q;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] stat_rev;

    assign rise     = sck_s && !sck_d;
    assign fall     = !sck_s && sck_d;
    assign cmd_full = {cmd_sh[CMD_W-2:0], mosi_s};

    always_comb begin
        status = {ovf, 1'b0, level};
        for (int k = 0; k < STAT_W; k++) begin
            stat_rev[k] = status[STAT_W-1-k];
        end
    end

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            SP_IDLE: if (!csn_s) st_n = SP_CMD;
            SP_CMD: begin
                if (csn_s) begin
                    st_n = SP_IDLE;
                end else if (rise && bit_cnt == CMD_LAST) begin
                    st_n = (cmd_full == RD_OPCODE) ? SP_DATA : SP_SKIP;
                end
            end
            SP_DATA: begin
                if (csn_s) begin
                    st_n = SP_IDLE;
                end else if (rise && bit_cnt == FRM_LAST) begin
                    st_n = SP_DONE;
                end
            end
            SP_DONE: if (csn_s) st_n = SP_IDLE;
            SP_SKIP: if (csn_s) st_n = SP_IDLE;
            default: st_n = SP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SP_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_s   <= 1'b1;
            sck_s   <= 1'b0;
            sck_d   <= 1'b0;
            mosi_s  <= 1'b0;
            bit_cnt <= '0;
            cmd_sh  <= '0;
            sh_q    <= '0;
            out_q   <= 1'b0;
            rep_q   <= '0;
        end else begin
            csn_s  <= spi_csn;
            sck_s  <= spi_sck;
            sck_d  <= sck_s;
            mosi_s <= spi_mosi;
            if (csn_s) begin
                bit_cnt <= '0;
            end else if (rise && bit_cnt != FRM_END) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (st == SP_CMD && rise) begin
                cmd_sh <= cmd_full;
            end
            if (st == SP_CMD && st_n == SP_DATA) begin
                sh_q  <= {stat_rev, window};
                rep_q <= level;
            end else if (st == SP_DATA && fall) begin
                out_q <= sh_q[0];
                sh_q  <= sh_q >> 1;
            end
        end
    end

    // outputs
    always_comb begin
        sdo_en   = !spi_csn && (st == SP_DATA || st == SP_DONE);
        sdo_data = out_q;
        commit   = (st == SP_DONE) && csn_s;
        commit_n = rep_q;
    end

    a_r2_load_at_cmd_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SP_DATA && $past(st) == SP_CMD) |-> (bit_cnt == FRM_CW'(CMD_W)))
        else $error("R2: window loaded away from the command boundary");

    a_r4_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit)
        else $error("R4: read committed twice");

endmodule

// File: rtl/bfifo_irq.sv
module bfifo_irq
    import bfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msg_end,
    input  logic lock_en,
    input  logic slave_run,
    input  logic irq_high,
    input  logic release_i,
    output logic irq_o,
    output logic locked
);

    irq_st_e st, st_n;
    logic    lvl;

    always_comb begin
        st_n = st;
        unique case (st)
            IQ_IDLE, IQ_PULSE: begin
                if (msg_end) begin
                    st_n = (lock_en && slave_run) ? IQ_HOLD : IQ_PULSE;
                end else begin
                    st_n = IQ_IDLE;
                end
            end
            IQ_HOLD: if (release_i) st_n = IQ_IDLE;
            default: st_n = IQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= IQ_IDLE;
        end else begin
            st <= st_n;
        end
    end

    always_comb begin
        lvl    = (st != IQ_IDLE);
        irq_o  = irq_high ? lvl : !lvl;
        locked = (st == IQ_HOLD);
    end

    a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !release_i) |=> locked)
        else $error("R10: lock released without a read");

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IQ_PULSE && !msg_end) |=> !lvl)
        else $error("R9: interrupt pulse longer than one cycle");

endmodule

// File: rtl/bitfifo_spi_rd.sv
module bitfifo_spi_rd #(
    parameter int         DEPTH     = 32,
    parameter int         CMD_W     = 8,
    parameter logic [7:0] RD_OPCODE = 8'h3C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic frm_start,
    input  logic msg_end,
    input  logic cycle_start,
    input  logic cfg_init_cycle,
    input  logic cfg_init_frame,
    input  logic cfg_lock_en,
    input  logic slave_run,
    input  logic cfg_irq_high,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic sdo_data,
    output logic sdo_en,
    output logic irq_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] window;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] commit_n;
    logic             ovf, commit, locked;
    logic             init_req, ovf_clr, wr_en;

    assign ovf_clr  = frm_start && ovf;
    assign init_req = (cycle_start && cfg_init_cycle)
                    || ovf_clr
                    || (frm_start && cfg_init_frame && !locked);
    assign wr_en    = bit_valid && !locked;

    bfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bit   (bit_data),
        .init_req (init_req),
        .ovf_clr  (ovf_clr),
        .commit   (commit),
        .commit_n (commit_n),
        .window   (window),
        .level    (level),
        .ovf      (ovf)
    );

    bfifo_spi #(.DEPTH(DEPTH), .CMD_W(CMD_W), .RD_OPCODE(RD_OPCODE)) u_spi (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_csn  (spi_csn),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .window   (window),
        .level    (level),
        .ovf      (ovf),
        .sdo_data (sdo_data),
        .sdo_en   (sdo_en),
        .commit   (commit),
        .commit_n (commit_n)
    );

    bfifo_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_end   (msg_end),
        .lock_en   (cfg_lock_en),
        .slave_run (slave_run),
        .irq_high  (cfg_irq_high),
        .release_i (commit),
        .irq_o     (irq_o),
        .locked    (locked)
    );

    a_r12_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !sdo_en)
        else $error("R12: serial output driven while deselected");

    a_r10_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !init_req && !commit && !ovf_clr) |=> $stable(level))
        else $error("R10: stored count moved while locked");

endmodule

// File: tb/bitfifo_spi_rd_tb_top.sv
`timescale 1ns/1ps
module bitfifo_spi_rd_tb_top;

    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam logic [7:0] OPC = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 0, bit_data = 0, frm_start = 0, msg_end = 0, cycle_start = 0;
    logic cfg_init_cycle = 0, cfg_init_frame = 0, cfg_lock_en = 0, slave_run = 0;
    logic cfg_irq_high = 1;
    logic spi_csn = 1, spi_sck = 0, spi_mosi = 0;
    logic sdo_data, sdo_en, irq_o;

    int checks = 0;
    int errors = 0;
    int settle = 4;

    // reference model state
    bit q[$];
    bit m_ovf = 0;
    bit m_hold = 0;
    bit m_pulse = 0;

    always #(CLK_P/2) clk = ~clk;

    bitfifo_spi_rd dut_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .frm_start(frm_start), .msg_end(msg_end), .cycle_start(cycle_start),
        .cfg_init_cycle(cfg_init_cycle), .cfg_init_frame(cfg_init_frame),
        .cfg_lock_en(cfg_lock_en), .slave_run(slave_run), .cfg_irq_high(cfg_irq_high),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .sdo_data(sdo_data), .sdo_en(sdo_en), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // interrupt model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pulse = 0;
        end else if (msg_end) begin
            if (cfg_lock_en && slave_run) m_hold = 1;
            else m_pulse = 1;
        end else begin
            m_pulse = 0;
        end
    end

    // per-clock comparison, a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (settle > 0) begin
            settle--;
        end else begin
            check(irq_o === (cfg_irq_high ? (m_hold | m_pulse) : !(m_hold | m_pulse)),
                  "R9 R10 R11 irq level", irq_o, cfg_irq_high ? (m_hold | m_pulse) : !(m_hold | m_pulse));
            if (spi_csn) check(sdo_en === 1'b0, "R12 deselected output", sdo_en, 0);
        end
    end

    task automatic push(input bit b);
        @(negedge clk);
        bit_valid = 1; bit_data = b;
        @(negedge clk);
        bit_valid = 0;
        if (!m_hold) begin
            if (q.size() == 32) begin
                m_ovf = 1;
                void'(q.pop_front());
            end
            q.push_back(b);
        end
    endtask

    task automatic push_word(input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) push(pat[i]);
    endtask

    task automatic pulse_frm();
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0;
        if (m_ovf) begin
            m_ovf = 0; q.delete();
        end else if (cfg_init_frame && !m_hold) begin
            q.delete();
        end
    endtask

    task automatic pulse_cycle();
        @(negedge clk); cycle_start = 1;
        @(negedge clk); cycle_start = 0;
        if (cfg_init_cycle) q.delete();
    endtask

    task automatic pulse_end(input string req);
        bit lock;
        lock = cfg_lock_en && slave_run;
        @(negedge clk); msg_end = 1;
        @(negedge clk); msg_end = 0;
        check(irq_o === cfg_irq_high, {req, " irq active after end-of-message"}, irq_o, cfg_irq_high);
        @(negedge clk);
        check(irq_o === (lock ? cfg_irq_high : !cfg_irq_high), {req, " irq one cycle later"},
              irq_o, lock ? cfg_irq_high : !cfg_irq_high);
    endtask

    // one SPI frame; nbits < 48 aborts early
    task automatic spi_read(input logic [7:0] op, input int nbits, input string req);
        logic [31:0] got;
        logic [7:0]  st;
        bit          en_bad;
        int          e_cnt;
        bit          e_ovf;
        logic [31:0] e_dat;
        bit          match;
        int          bad_bits;
        got = '0; st = '0; en_bad = 0; bad_bits = 0;
        match = (op == OPC);
        e_cnt = q.size();
        e_ovf = m_ovf;
        e_dat = '0;
        for (int i = 0; i < e_cnt; i++) e_dat[i] = q[i];
        @(negedge clk); spi_csn = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 0;
            spi_mosi = (i < 8) ? op[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 40) got[i-8] = sdo_data;
            if (i >= 40) st[47-i] = sdo_data;
            if (i >= 8 && sdo_en !== match) en_bad = 1;
            spi_sck = 1;
            repeat (HALF) @(negedge clk);
        end
        spi_sck = 0;
        repeat (HALF) @(negedge clk);
        spi_csn = 1;
        settle = 8;
        if (match && nbits == 48) begin
            for (int i = 0; i < e_cnt; i++) void'(q.pop_front());
            m_hold = 0;
        end
        repeat (10) @(negedge clk);
        if (nbits < 9) return;
        check(!en_bad, {req, " output enable during frame"}, en_bad, 0);
        if (!match || nbits < 48) return;
        check(st[7] == e_ovf, {req, " R3 overflow bit"}, st[7], e_ovf);
        if (!e_ovf) begin
            check(st[5:0] == 6'(e_cnt), {req, " R3 count field"}, st[5:0], e_cnt);
            for (int i = 0; i < e_cnt; i++) if (got[i] !== e_dat[i]) bad_bits++;
            check(bad_bits == 0, {req, " R2 window bits"}, got, e_dat);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(irq_o === 1'b0, "R1 irq after reset", irq_o, 0);
        check(sdo_en === 1'b0, "R1 sdo_en after reset", sdo_en, 0);
        spi_read(OPC, 48, "R1 empty read");

        // R2 R3 R4: ordering and drain
        push_word(5, 32'b01101);
        spi_read(OPC, 48, "R2 five bits");
        spi_read(OPC, 48, "R4 drained");

        // R4: aborted frame keeps data
        push_word(12, 32'hA5C);
        spi_read(OPC, 20, "R4 abort");
        spi_read(OPC, 48, "R4 after abort");

        // R3: exactly 32 stored, no overflow
        push_word(32, 32'hC3A5_0F96);
        spi_read(OPC, 48, "R3 full window");

        // R5 R6: overflow, sticky, cleared by frame start
        push_word(32, 32'h1234_5678);
        push(1);
        spi_read(OPC, 48, "R5 overflow set");
        spi_read(OPC, 48, "R5 overflow sticky");
        pulse_frm();
        spi_read(OPC, 48, "R6 cleared");

        // R7: cycle start
        push_word(4, 32'h9);
        pulse_cycle();
        spi_read(OPC, 48, "R7 option off");
        cfg_init_cycle = 1;
        push_word(4, 32'h6);
        pulse_cycle();
        spi_read(OPC, 48, "R7 option on");
        cfg_init_cycle = 0;

        // R8: frame start init
        push_word(6, 32'h2D);
        pulse_frm();
        spi_read(OPC, 48, "R8 option off");
        cfg_init_frame = 1;
        push_word(6, 32'h1B);
        pulse_frm();
        spi_read(OPC, 48, "R8 option on");

        // R9: pulse, lock off and lock on without slave run
        pulse_end("R9 no lock");
        cfg_lock_en = 1;
        pulse_end("R9 lock but not slave run");

        // R10: hold and lock
        slave_run = 1;
        push_word(3, 32'h5);
        pulse_end("R10 lock");
        push_word(2, 32'h3);
        pulse_frm();
        repeat (30) @(negedge clk);
        check(irq_o === 1'b1, "R10 irq still held", irq_o, 1);
        spi_read(OPC, 48, "R10 locked contents");
        check(irq_o === 1'b0, "R10 irq released after read", irq_o, 0);
        cfg_lock_en = 0; slave_run = 0; cfg_init_frame = 0;

        // R11: active-low polarity
        @(negedge clk); cfg_irq_high = 0;
        @(negedge clk);
        check(irq_o === 1'b1, "R11 idle level active-low", irq_o, 1);
        pulse_end("R11 active-low pulse");
        cfg_irq_high = 1;

        // R12: foreign command
        push_word(4, 32'hB);
        spi_read(8'h00, 48, "R12 foreign opcode");
        spi_read(OPC, 48, "R12 contents kept");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule